// File: doc/BRIEF.md
# Absolute-Mode Bus Sequencer

This block steps an 8-bit processor with a 16-bit address through the bus cycles of two instructions. The first, opcode AD, loads the accumulator from an absolute address. The second, opcode 8D, stores the accumulator to an absolute address. Every processor cycle is split into two halves. A `phase` input marks each clock edge: 0 for the edge that opens the first half (phi1) and 1 for the edge that opens the second half (phi2). Address and read/write direction are issued at the phi1 edge. Read data is taken, or write data is put out, at the phi2 edge. Any other opcode runs as a two-cycle no-operation.

The core is a five-state machine. `ST_OPCODE` fetches the opcode at the program counter. `ST_ADDR_LO` and `ST_ADDR_HI` fetch the two operand bytes. `ST_ACCESS` reads or writes the effective address. `ST_IDLE_READ` is the dummy read of a no-operation. The machine moves only at phi2 edges, along these transitions:
- opcode-to-operand on AD or 8D, and opcode-to-idle on any other opcode;
- low-to-high;
- high-to-access;
- access-to-opcode;
- idle-to-opcode.

The active-low interrupt request is sampled at each phi1 edge into a pending flag, and the flag is cleared at each phi2 edge. The flag is an output so that the sampling can be observed.

Top module: `abs_bus_seq`

## Requirements
- R1: While `rst_n` is low, `pc` is 0000, `addr` is 0000, `rw` is 1, `data_oe` is 0, `acc` is 00 and `irq_pending` is 0. The first cycle after reset is an opcode fetch from 0000.
- R2: An instruction with opcode AD or 8D fetched at address P takes four cycles. The addresses are P, P+1, P+2 and then the effective address. The next opcode is fetched from P+3.
- R3: During each fetch cycle, `pc` shows the address being fetched. It advances by one at the phi1 edge after the opcode, low-byte and high-byte cycles. It does not advance after the access cycle or the dummy cycle, and it never changes at a phi2 edge.
- R4: The effective address is the second operand byte (high) joined above the first operand byte (low). For example, bytes 34 then 12 give 1234.
- R5: `rw` is 1 (read) in every cycle except the access cycle of opcode 8D, where it is 0.
- R6: `addr` and `rw` change only at phi1 edges. They hold their value across the phi2 half.
- R7: For opcode AD, `acc` takes the value on `data_in` at the phi2 edge of the access cycle. The value on `data_in` at the phi1 edge is ignored.
- R8: For opcode 8D, `data_oe` is 1 and `data_out` equals `acc` only during the phi2 half of the access cycle. At all other times `data_oe` is 0.
- R9: After a phi1 edge, `irq_pending` equals the inverse of `irq_n` sampled at that edge. After a phi2 edge, it is 0.
- R10: Any opcode other than AD or 8D takes two cycles. The second is a read at P+1 with no further `pc` advance. The next opcode comes from P+1, and `acc` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; two rising edges per processor cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| phase | input | 1 | Half marker for this edge: 0 opens phi1, 1 opens phi2 |
| data_in | input | 8 | Data bus input |
| irq_n | input | 1 | Active-low interrupt request |
| addr | output | 16 | Address bus |
| data_out | output | 8 | Write data |
| data_oe | output | 1 | Write data enable |
| rw | output | 1 | 1 = read, 0 = write |
| pc | output | 16 | Program counter |
| acc | output | 8 | Accumulator |
| irq_pending | output | 1 | Interrupt request sampled at the last phi1 edge |

## Verification
Directed loads and stores use the operand pair 34/12 and also extreme operand bytes (00 and FF). These show whether the effective address is built in the high/low order. Near-miss opcodes such as AC and 8C must fall into the two-cycle path, which tells true decode apart from partial bit matches. A random mix of loads, stores and other opcodes follows, with random operands. It puts junk on the data bus at every phi1 edge, so capture at the wrong half shows up as a wrong accumulator. It also toggles the interrupt request independently in each half, which separates phi1 sampling from phi2 clearing.

// File: rtl/abs_seq_pkg.sv
package abs_seq_pkg;

    typedef enum logic [2:0] {
        ST_OPCODE,
        ST_ADDR_LO,
        ST_ADDR_HI,
        ST_ACCESS,
        ST_IDLE_READ
    } step_t;

    typedef enum logic [1:0] {
        OPK_LOAD,
        OPK_STORE,
        OPK_OTHER
    } opkind_t;

endpackage

// File: rtl/seq_fsm.sv
module seq_fsm
    import abs_seq_pkg::*;
#(
    parameter int          DATA_W   = 8,
    parameter logic [7:0]  OP_LOAD  = 8'hAD,
    parameter logic [7:0]  OP_STORE = 8'h8D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase,
    input  logic [DATA_W-1:0] data_in,
    output step_t             step,
    output logic              from_pc,
    output logic              bump_pc,
    output logic              write_cyc,
    output logic              load_cyc
);

    step_t   step_nx;
    opkind_t kind, kind_nx;

    // state register: advances only at phi2 edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step <= ST_OPCODE;
            kind <= OPK_OTHER;
        end else if (phase) begin
            step <= step_nx;
            if (step == ST_OPCODE)
                kind <= kind_nx;
        end
    end

    // next state and cycle decodes
    always_comb begin
        if (data_in[7:0] == OP_LOAD)
            kind_nx = OPK_LOAD;
        else if (data_in[7:0] == OP_STORE)
            kind_nx = OPK_STORE;
        else
            kind_nx = OPK_OTHER;

        step_nx   = ST_OPCODE;
        from_pc   = 1'b1;
        bump_pc   = 1'b0;
        write_cyc = 1'b0;
        load_cyc  = 1'b0;
        unique case (step)
            ST_OPCODE: begin
                step_nx = (kind_nx == OPK_OTHER) ? ST_IDLE_READ : ST_ADDR_LO;
                bump_pc = 1'b1;
            end
            ST_ADDR_LO: begin
                step_nx = ST_ADDR_HI;
                bump_pc = 1'b1;
            end
            ST_ADDR_HI: begin
                step_nx = ST_ACCESS;
                bump_pc = 1'b1;
            end
            ST_ACCESS: begin
                step_nx   = ST_OPCODE;
                from_pc   = 1'b0;
                write_cyc = (kind == OPK_STORE);
                load_cyc  = (kind == OPK_LOAD);
            end
            ST_IDLE_READ: begin
                step_nx = ST_OPCODE;
            end
            default: begin
                step_nx = ST_OPCODE;
            end
        endcase
    end

endmodule

// File: rtl/seq_pc.sv
module seq_pc #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase,
    input  logic              bump_pc,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] pc_fetch
);

    logic inc_pend;

    assign pc_fetch = inc_pend ? pc + ADDR_W'(1) : pc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc       <= '0;
            inc_pend <= 1'b0;
        end else if (!phase) begin
            pc       <= pc_fetch;
            inc_pend <= 1'b0;
        end else begin
            inc_pend <= bump_pc;
        end
    end

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
    import abs_seq_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase,
    input  step_t             step,
    input  logic              load_cyc,
    input  logic              write_cyc,
    input  logic [DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0] eff_addr,
    output logic [DATA_W-1:0] acc,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe
);

    logic [DATA_W-1:0] lo_q, hi_q;

    assign eff_addr = {hi_q, lo_q};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q     <= '0;
            hi_q     <= '0;
            acc      <= '0;
            data_out <= '0;
            data_oe  <= 1'b0;
        end else if (!phase) begin
            data_oe <= 1'b0;
        end else begin
            if (step == ST_ADDR_LO) lo_q <= data_in;
            if (step == ST_ADDR_HI) hi_q <= data_in;
            if (load_cyc)           acc  <= data_in;
            if (write_cyc) begin
                data_out <= acc;
                data_oe  <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/seq_bus_irq.sv
module seq_bus_irq #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase,
    input  logic              from_pc,
    input  logic              write_cyc,
    input  logic [ADDR_W-1:0] pc_fetch,
    input  logic [ADDR_W-1:0] eff_addr,
    input  logic              irq_n,
    output logic [ADDR_W-1:0] addr,
    output logic              rw,
    output logic              irq_pending
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr        <= '0;
            rw          <= 1'b1;
            irq_pending <= 1'b0;
        end else if (!phase) begin
            addr        <= from_pc ? pc_fetch : eff_addr;
            rw          <= !write_cyc;
            irq_pending <= !irq_n;
        end else begin
            irq_pending <= 1'b0;
        end
    end

endmodule

// File: rtl/abs_bus_seq.sv
module abs_bus_seq
    import abs_seq_pkg::*;
#(
    parameter int          DATA_W   = 8,
    parameter logic [7:0]  OP_LOAD  = 8'hAD,
    parameter logic [7:0]  OP_STORE = 8'h8D,
    localparam int         ADDR_W   = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase,
    input  logic [DATA_W-1:0] data_in,
    input  logic              irq_n,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              rw,
    output logic [ADDR_W-1:0] pc,
    output logic [DATA_W-1:0] acc,
    output logic              irq_pending
);

    step_t             step;
    logic              from_pc, bump_pc, write_cyc, load_cyc;
    logic [ADDR_W-1:0] pc_fetch, eff_addr;

    seq_fsm #(.DATA_W(DATA_W), .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE)) i_fsm (
        .clk(clk), .rst_n(rst_n), .phase(phase), .data_in(data_in),
        .step(step), .from_pc(from_pc), .bump_pc(bump_pc),
        .write_cyc(write_cyc), .load_cyc(load_cyc)
    );

    seq_pc #(.ADDR_W(ADDR_W)) i_pc (
        .clk(clk), .rst_n(rst_n), .phase(phase), .bump_pc(bump_pc),
        .pc(pc), .pc_fetch(pc_fetch)
    );

    seq_datapath #(.DATA_W(DATA_W)) i_dp (
        .clk(clk), .rst_n(rst_n), .phase(phase), .step(step),
        .load_cyc(load_cyc), .write_cyc(write_cyc), .data_in(data_in),
        .eff_addr(eff_addr), .acc(acc), .data_out(data_out), .data_oe(data_oe)
    );

    seq_bus_irq #(.ADDR_W(ADDR_W)) i_bus (
        .clk(clk), .rst_n(rst_n), .phase(phase), .from_pc(from_pc),
        .write_cyc(write_cyc), .pc_fetch(pc_fetch), .eff_addr(eff_addr),
        .irq_n(irq_n), .addr(addr), .rw(rw), .irq_pending(irq_pending)
    );

endmodule

// File: rtl/abs_bus_seq_chk.sv
module abs_bus_seq_chk #(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              phase,
    input logic              irq_n,
    input logic [ADDR_W-1:0] addr,
    input logic              data_oe,
    input logic              rw,
    input logic [ADDR_W-1:0] pc,
    input logic              irq_pending
);

    p_bus_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        phase |=> ($stable(addr) && $stable(rw)));

    p_pc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        phase |=> $stable(pc));

    p_pc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !phase |=> (pc == $past(pc) || pc == $past(pc) + ADDR_W'(1)));

    p_oe_off_phi1_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !phase |=> !data_oe);

    p_oe_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> !rw);

    p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        phase |=> !irq_pending);

    p_irq_sample_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !phase |=> (irq_pending == !$past(irq_n)));

endmodule

bind abs_bus_seq abs_bus_seq_chk #(.DATA_W(DATA_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .phase(phase), .irq_n(irq_n), .addr(addr),
    .data_oe(data_oe), .rw(rw), .pc(pc), .irq_pending(irq_pending)
);

// File: tb/test_abs_bus_seq.sv
module test_abs_bus_seq;

    localparam int CLK_PERIOD = 10;
    localparam int SEED       = 32'd5021;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phase = 1'b0;
    logic [7:0]  data_in = 8'h00;
    logic        irq_n = 1'b1;
    logic [15:0] addr, pc;
    logic [7:0]  data_out, acc;
    logic        data_oe, rw, irq_pending;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [15:0] pc_exp;
    logic [7:0]  acc_exp;

    abs_bus_seq i_abs_bus_seq (
        .clk(clk), .rst_n(rst_n), .phase(phase), .data_in(data_in), .irq_n(irq_n),
        .addr(addr), .data_out(data_out), .data_oe(data_oe), .rw(rw),
        .pc(pc), .acc(acc), .irq_pending(irq_pending)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit is_abs(input logic [7:0] op);
        return (op == 8'hAD) || (op == 8'h8D);
    endfunction

    function automatic logic [7:0] pick_other();
        logic [7:0] v;
        v = 8'($urandom);
        while (is_abs(v)) v = 8'($urandom);
        return v;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic half(input logic ph, input logic [7:0] din, input logic irq);
        phase   = ph;
        data_in = din;
        irq_n   = irq;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_cycle(input string areq, input logic [15:0] ea, input logic [15:0] ep,
                             input logic erw, input logic [7:0] din, input bit ld, input bit st);
        logic irq1, irq2;
        irq1 = 1'($urandom);
        irq2 = 1'($urandom);
        // phi1: junk on the data bus must be ignored (R7)
        half(1'b0, 8'($urandom), irq1);
        check(areq, 32'(addr), 32'(ea));
        check("R3 pc", 32'(pc), 32'(ep));
        check("R5 rw", 32'(rw), 32'(erw));
        check("R9 irq sample", 32'(irq_pending), 32'(!irq1));
        check("R8 oe phi1", 32'(data_oe), 32'd0);
        // phi2
        half(1'b1, din, irq2);
        check("R6 addr hold", 32'(addr), 32'(ea));
        check("R6 rw hold", 32'(rw), 32'(erw));
        check("R3 pc hold", 32'(pc), 32'(ep));
        check("R9 irq clear", 32'(irq_pending), 32'd0);
        if (ld) acc_exp = din;
        check("R7 acc", 32'(acc), 32'(acc_exp));
        check("R8 oe phi2", 32'(data_oe), 32'(st));
        if (st) check("R8 data_out", 32'(data_out), 32'(acc_exp));
    endtask

    task automatic run_instr(input logic [7:0] op, input logic [7:0] lo, input logic [7:0] hi,
                             input logic [7:0] val);
        logic [15:0] p;
        logic [7:0]  acc_before;
        bit          st;
        p  = pc_exp;
        st = (op == 8'h8D);
        bus_cycle("R2 opcode addr", p, p, 1'b1, op, 1'b0, 1'b0);
        if (is_abs(op)) begin
            bus_cycle("R2 low addr", p + 16'd1, p + 16'd1, 1'b1, lo, 1'b0, 1'b0);
            bus_cycle("R2 high addr", p + 16'd2, p + 16'd2, 1'b1, hi, 1'b0, 1'b0);
            bus_cycle("R4 effective addr", {hi, lo}, p + 16'd3, !st,
                      st ? 8'($urandom) : val, !st, st);
            pc_exp = p + 16'd3;
        end else begin
            acc_before = acc_exp;
            bus_cycle("R10 dummy addr", p + 16'd1, p + 16'd1, 1'b1, 8'($urandom), 1'b0, 1'b0);
            check("R10 acc unchanged", 32'(acc), 32'(acc_before));
            pc_exp = p + 16'd1;
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int r;
        void'($urandom(SEED));
        pc_exp  = 16'h0000;
        acc_exp = 8'h00;
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            half(1'b0, 8'hA5, 1'b0);
            half(1'b1, 8'h5A, 1'b0);
        end
        check("R1 pc", 32'(pc), 32'h0);
        check("R1 addr", 32'(addr), 32'h0);
        check("R1 rw", 32'(rw), 32'd1);
        check("R1 oe", 32'(data_oe), 32'd0);
        check("R1 acc", 32'(acc), 32'h0);
        check("R1 irq_pending", 32'(irq_pending), 32'd0);
        rst_n = 1'b1;

        // directed: first fetch at 0000 (R1), classic operand order (R4)
        run_instr(8'hAD, 8'h34, 8'h12, 8'hC3);
        run_instr(8'h8D, 8'h34, 8'h12, 8'h00);
        run_instr(8'hEA, 8'h00, 8'h00, 8'h00);
        run_instr(8'hAC, 8'h00, 8'h00, 8'h00);
        run_instr(8'h8C, 8'h00, 8'h00, 8'h00);
        run_instr(8'hAD, 8'hFF, 8'h00, 8'h7E);
        run_instr(8'h8D, 8'h00, 8'hFF, 8'h00);
        run_instr(8'h00, 8'h00, 8'h00, 8'h00);

        // constrained random mix
        for (int n = 0; n < 40; n++) begin
            r = $urandom_range(0, 9);
            if (r < 4)
                run_instr(8'hAD, 8'($urandom), 8'($urandom_range(1, 255)), 8'($urandom));
            else if (r < 8)
                run_instr(8'h8D, 8'($urandom), 8'($urandom_range(1, 255)), 8'h00);
            else
                run_instr(pick_other(), 8'h00, 8'h00, 8'h00);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule